// File: doc/BRIEF.md
# Page Access Permission Checker

This combinational block decides which rights a memory access has on a translated page, and whether the requested access breaks them. Three masks are formed on their own and then ANDed into one read/write/execute set. The first comes from the page's protection code, read through the segment key that the privilege state selects. The second comes from the page's no-execute and guarded bits. The third comes from a storage-class key: the key picks a 2-bit field out of a data authority mask and out of an instruction authority mask.

The requested access (load, store or fetch) is compared with the combined set. A denial raises a fault flag and a set of reason bits. The reason bits come in one of two formats, one for instruction fetches and one for data accesses, so the exception logic downstream can copy them straight into its status registers. The table walk, the storage of the mask registers and the raising of the interrupt all sit outside this block. The mask registers reach it as plain inputs.

Top module: `page_perm_check`

## Requirements
- R1: The segment key used for the protection code is `key_super_i` when `priv_i` is 1 and `key_user_i` when `priv_i` is 0.
- R2: The 3-bit protection code is {`pte_pp0_i`, `pte_pp_i[1:0]`}. With key 0, codes 0, 1 and 2 grant read+write+execute, codes 3 and 6 grant read+execute, and any other code grants nothing. With key 1, code 2 grants read+write+execute, codes 1, 3 and 6 grant read+execute, and any other code grants nothing.
- R3: If `pte_noexec_i` or `pte_guard_i` is 1, execute is removed from the result while read and write are not affected.
- R4: The page class key `pte_key_i` selects bits [2*(NKEYS-1-key)+1 : 2*(NKEYS-1-key)] of `amr_i`. The upper bit of that field removes write and the lower bit removes read.
- R5: The lower bit of the field that `pte_key_i` selects in `iamr_i` removes execute, but only when `gen_i` is 2 or 3. For `gen_i` 0 and 1, `iamr_i` has no effect.
- R6: When `keyprot_en_i` is 0, neither `amr_i` nor `iamr_i` removes any right.
- R7: `perm_o` is the AND of the three masks. Rights are encoded as bit0 = read, bit1 = write, bit2 = execute. `fault_o` is 1 exactly when `access_i` requests a right that `perm_o` lacks.
- R8: On a fetch fault, `fetch_why_o` is set as follows. Bit0 is set when the no-execute/guard mask removed execute. Bit1 is set when that mask did not remove execute but the protection code did. Bit2 is set when the class-key mask removed execute.
- R9: On a load or store fault, `data_why_o` is set as follows. Bit0 is set when the protection-code mask denied the request. Bit1 is set for stores. Bit2 is set when the class-key mask denied the request.
- R10: Without a fault, both reason outputs are zero. A fetch never drives `data_why_o`, and a data access never drives `fetch_why_o`.
- R11: `access_i` is one-hot: 3'b001 is a load, 3'b010 is a store and 3'b100 is a fetch. An all-zero request never faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| priv_i | input | 1 | 1 = privileged access |
| key_user_i | input | 1 | Segment key for unprivileged accesses |
| key_super_i | input | 1 | Segment key for privileged accesses |
| pte_pp_i | input | 2 | Low two bits of the page protection code |
| pte_pp0_i | input | 1 | Top bit of the page protection code |
| pte_noexec_i | input | 1 | Page no-execute bit |
| pte_guard_i | input | 1 | Page guarded bit |
| pte_key_i | input | KEY_W (5) | Page storage-class key |
| gen_i | input | 2 | Architecture generation, 0..3 |
| keyprot_en_i | input | 1 | Enables class-key protection |
| amr_i | input | MASK_W (64) | Data authority mask |
| iamr_i | input | MASK_W (64) | Instruction authority mask |
| access_i | input | 3 | Requested access, one-hot |
| perm_o | output | 3 | Combined rights |
| fault_o | output | 1 | Requested access denied |
| fetch_why_o | output | 3 | Fetch fault reasons |
| data_why_o | output | 3 | Data fault reasons |

## Verification
The bench sweeps every combination of privilege, both segment keys, all eight protection codes, no-execute and guard, the three access types, all four generations, the key enable, and every value of the selected mask fields. The key rotates through all 32 values, and each non-selected mask field holds the complement of the selected one. A wrong key shift therefore reads inverted bits and shows up as a mismatch in `perm_o`. Protection codes 4, 5 and 7 test that undefined codes grant nothing; a design that decoded only the two low bits would grant rights there. For fetch faults denied by both the guard mask and the protection code, the bench expects only the guard reason. A design that set both reasons, or that let the instruction mask act in generations 0 and 1, would miscompare.

// File: rtl/perm_pkg.sv
package perm_pkg;

  typedef logic [2:0] rights_t;

  localparam rights_t RT_NONE = 3'b000;
  localparam rights_t RT_R    = 3'b001;
  localparam rights_t RT_W    = 3'b010;
  localparam rights_t RT_X    = 3'b100;
  localparam rights_t RT_RX   = 3'b101;
  localparam rights_t RT_ALL  = 3'b111;

  typedef enum logic [1:0] {
    GEN_EARLY   = 2'd0,
    GEN_MID     = 2'd1,
    GEN_FETCHKY = 2'd2,
    GEN_LATEST  = 2'd3
  } arch_gen_e;

  // Rights granted by a protection code under a given segment key.
  function automatic rights_t pp_rights(input logic key, input logic [2:0] code);
    rights_t r;
    r = RT_NONE;
    if (!key) begin
      case (code)
        3'd0, 3'd1, 3'd2: r = RT_ALL;
        3'd3, 3'd6:       r = RT_RX;
        default:          r = RT_NONE;
      endcase
    end else begin
      case (code)
        3'd2:             r = RT_ALL;
        3'd1, 3'd3, 3'd6: r = RT_RX;
        default:          r = RT_NONE;
      endcase
    end
    return r;
  endfunction

  // Bit offset of the 2-bit field for a key; key 0 sits at the top.
  function automatic int unsigned key_field_lsb(input int unsigned key, input int unsigned nkeys);
    return 2 * (nkeys - 1 - key);
  endfunction

  // Rights left after a data field and an instruction-block flag.
  function automatic rights_t class_rights(input logic [1:0] dfield, input logic xblock);
    rights_t r;
    r = RT_ALL;
    if (dfield[1]) r = r & ~RT_W;
    if (dfield[0]) r = r & ~RT_R;
    if (xblock)    r = r & ~RT_X;
    return r;
  endfunction

endpackage

// File: rtl/pp_authority.sv
module pp_authority
  import perm_pkg::*;
(
  input  logic       priv_i,
  input  logic       key_user_i,
  input  logic       key_super_i,
  input  logic [1:0] pp_lo_i,
  input  logic       pp_hi_i,
  output logic       sel_key_o,
  output rights_t    pp_mask_o
);

  logic [2:0] code;

  assign sel_key_o = priv_i ? key_super_i : key_user_i;
  assign code      = {pp_hi_i, pp_lo_i};
  assign pp_mask_o = pp_rights(sel_key_o, code);

  always_comb begin
    // R2: no protection code grants write without read
    p_write_needs_read_r2: assert (!(pp_mask_o[1] && !pp_mask_o[0]));
    // R1: with both keys equal the privilege bit cannot change the result
    if (key_user_i == key_super_i)
      p_key_agree_r1: assert (sel_key_o == key_user_i);
  end

endmodule

// File: rtl/exec_guard.sv
module exec_guard
  import perm_pkg::*;
(
  input  logic    noexec_i,
  input  logic    guard_i,
  output rights_t exec_mask_o
);

  logic strip_x;

  assign strip_x     = noexec_i | guard_i;
  assign exec_mask_o = strip_x ? (RT_ALL & ~RT_X) : RT_ALL;

  always_comb begin
    // R3: read and write always survive this mask
    p_rw_kept_r3: assert ((exec_mask_o & (RT_R | RT_W)) == (RT_R | RT_W));
    if (noexec_i || guard_i)
      p_x_removed_r3: assert (!exec_mask_o[2]);
  end

endmodule

// File: rtl/class_key_mask.sv
module class_key_mask
  import perm_pkg::*;
#(
  parameter  int KEY_W          = 5,
  parameter  int IAMR_FIRST_GEN = 2,
  localparam int NKEYS          = 1 << KEY_W,
  localparam int MASK_W         = 2 * NKEYS
) (
  input  logic [KEY_W-1:0]  key_i,
  input  logic [1:0]        gen_i,
  input  logic              en_i,
  input  logic [MASK_W-1:0] amr_i,
  input  logic [MASK_W-1:0] iamr_i,
  output rights_t           key_mask_o
);

  int unsigned lsb;
  logic [1:0]  dfield;
  logic        ifetch_gen;
  logic        xblock;

  always_comb begin
    lsb        = key_field_lsb(int'(key_i), NKEYS);
    dfield     = 2'(amr_i >> lsb);
    ifetch_gen = (int'(gen_i) >= IAMR_FIRST_GEN);
    xblock     = ifetch_gen && (((iamr_i >> lsb) & MASK_W'(1)) != '0);
    key_mask_o = en_i ? class_rights(dfield, xblock) : RT_ALL;
  end

  always_comb begin
    // R6: disabled key protection removes nothing
    if (!en_i)
      p_disabled_full_r6: assert (key_mask_o == RT_ALL);
    // R5: older generations never lose execute through this mask
    if (int'(gen_i) < IAMR_FIRST_GEN)
      p_iamr_gated_r5: assert (key_mask_o[2]);
  end

endmodule

// File: rtl/fault_report.sv
module fault_report
  import perm_pkg::*;
(
  input  rights_t    access_i,
  input  rights_t    pp_mask_i,
  input  rights_t    exec_mask_i,
  input  rights_t    key_mask_i,
  output rights_t    perm_o,
  output logic       fault_o,
  output logic [2:0] fetch_why_o,
  output logic [2:0] data_why_o
);

  rights_t denied;
  logic    is_fetch;
  logic    fetch_fault;
  logic    data_fault;

  assign perm_o      = pp_mask_i & exec_mask_i & key_mask_i;
  assign denied      = access_i & ~perm_o;
  assign fault_o     = |denied;
  assign is_fetch    = access_i[2];
  assign fetch_fault = fault_o && is_fetch;
  assign data_fault  = fault_o && !is_fetch;

  always_comb begin
    fetch_why_o = 3'b000;
    if (fetch_fault) begin
      fetch_why_o[0] = !exec_mask_i[2];
      fetch_why_o[1] = exec_mask_i[2] && !pp_mask_i[2];
      fetch_why_o[2] = !key_mask_i[2];
    end
  end

  always_comb begin
    data_why_o = 3'b000;
    if (data_fault) begin
      data_why_o[0] = |(access_i & ~pp_mask_i);
      data_why_o[1] = access_i[1];
      data_why_o[2] = |(access_i & ~key_mask_i);
    end
  end

  always_comb begin
    // R7: combined rights never exceed any single mask
    p_perm_subset_r7: assert ((perm_o & ~(pp_mask_i & key_mask_i)) == RT_NONE);
    // R10: reasons only accompany a fault, and only one format at a time
    if (!fault_o)
      p_quiet_reasons_r10: assert (fetch_why_o == 3'b000 && data_why_o == 3'b000);
    p_one_format_r10: assert (!(|fetch_why_o && |data_why_o));
    // R8: a denied fetch always names at least one cause
    if (fault_o && access_i == RT_X)
      p_fetch_cause_r8: assert (|fetch_why_o);
    // R9: a denied store always carries the store flag
    if (fault_o && access_i == RT_W)
      p_store_flag_r9: assert (data_why_o[1]);
    // R11: an empty request cannot fault
    if (access_i == RT_NONE)
      p_empty_ok_r11: assert (!fault_o);
  end

endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
  import perm_pkg::*;
#(
  parameter  int KEY_W          = 5,
  parameter  int IAMR_FIRST_GEN = 2,
  localparam int NKEYS          = 1 << KEY_W,
  localparam int MASK_W         = 2 * NKEYS
) (
  input  logic              priv_i,
  input  logic              key_user_i,
  input  logic              key_super_i,
  input  logic [1:0]        pte_pp_i,
  input  logic              pte_pp0_i,
  input  logic              pte_noexec_i,
  input  logic              pte_guard_i,
  input  logic [KEY_W-1:0]  pte_key_i,
  input  logic [1:0]        gen_i,
  input  logic              keyprot_en_i,
  input  logic [MASK_W-1:0] amr_i,
  input  logic [MASK_W-1:0] iamr_i,
  input  logic [2:0]        access_i,
  output logic [2:0]        perm_o,
  output logic              fault_o,
  output logic [2:0]        fetch_why_o,
  output logic [2:0]        data_why_o
);

  logic    sel_key;
  rights_t pp_mask;
  rights_t exec_mask;
  rights_t key_mask;

  pp_authority u_pp (
    .priv_i      (priv_i),
    .key_user_i  (key_user_i),
    .key_super_i (key_super_i),
    .pp_lo_i     (pte_pp_i),
    .pp_hi_i     (pte_pp0_i),
    .sel_key_o   (sel_key),
    .pp_mask_o   (pp_mask)
  );

  exec_guard u_xg (
    .noexec_i    (pte_noexec_i),
    .guard_i     (pte_guard_i),
    .exec_mask_o (exec_mask)
  );

  class_key_mask #(
    .KEY_W          (KEY_W),
    .IAMR_FIRST_GEN (IAMR_FIRST_GEN)
  ) u_key (
    .key_i      (pte_key_i),
    .gen_i      (gen_i),
    .en_i       (keyprot_en_i),
    .amr_i      (amr_i),
    .iamr_i     (iamr_i),
    .key_mask_o (key_mask)
  );

  fault_report u_rep (
    .access_i    (access_i),
    .pp_mask_i   (pp_mask),
    .exec_mask_i (exec_mask),
    .key_mask_i  (key_mask),
    .perm_o      (perm_o),
    .fault_o     (fault_o),
    .fetch_why_o (fetch_why_o),
    .data_why_o  (data_why_o)
  );

  always_comb begin
    // R1: an unprivileged access with key_user 0 and code 2 always has full rights from this mask
    if (!priv_i && !key_user_i && {pte_pp0_i, pte_pp_i} == 3'd2)
      p_user_key_full_r1: assert (pp_mask == RT_ALL && sel_key == 1'b0);
    // R3: a guarded page never ends up executable
    if (pte_guard_i)
      p_guard_no_exec_r3: assert (!perm_o[2]);
  end

endmodule

// File: tb/page_perm_check_tb_top.sv
module page_perm_check_tb_top;

  localparam int KEY_W  = 5;
  localparam int NKEYS  = 1 << KEY_W;
  localparam int MASK_W = 2 * NKEYS;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              priv_i       = 1'b0;
  logic              key_user_i   = 1'b0;
  logic              key_super_i  = 1'b0;
  logic [1:0]        pte_pp_i     = 2'b00;
  logic              pte_pp0_i    = 1'b0;
  logic              pte_noexec_i = 1'b0;
  logic              pte_guard_i  = 1'b0;
  logic [KEY_W-1:0]  pte_key_i    = '0;
  logic [1:0]        gen_i        = 2'b00;
  logic              keyprot_en_i = 1'b0;
  logic [MASK_W-1:0] amr_i        = '0;
  logic [MASK_W-1:0] iamr_i       = '0;
  logic [2:0]        access_i     = 3'b000;
  logic [2:0]        perm_o;
  logic              fault_o;
  logic [2:0]        fetch_why_o;
  logic [2:0]        data_why_o;

  page_perm_check dut_i (
    .priv_i       (priv_i),
    .key_user_i   (key_user_i),
    .key_super_i  (key_super_i),
    .pte_pp_i     (pte_pp_i),
    .pte_pp0_i    (pte_pp0_i),
    .pte_noexec_i (pte_noexec_i),
    .pte_guard_i  (pte_guard_i),
    .pte_key_i    (pte_key_i),
    .gen_i        (gen_i),
    .keyprot_en_i (keyprot_en_i),
    .amr_i        (amr_i),
    .iamr_i       (iamr_i),
    .access_i     (access_i),
    .perm_o       (perm_o),
    .fault_o      (fault_o),
    .fetch_why_o  (fetch_why_o),
    .data_why_o   (data_why_o)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  task automatic check3(input string tag, input logic [2:0] got, input logic [2:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  // Independent model of the rights from the protection code (R1, R2).
  function automatic logic [2:0] model_pp(input logic k, input int code);
    if (k == 1'b0) begin
      if (code <= 2) return 3'b111;
      if (code == 3 || code == 6) return 3'b101;
      return 3'b000;
    end
    if (code == 2) return 3'b111;
    if (code == 1 || code == 3 || code == 6) return 3'b101;
    return 3'b000;
  endfunction

  task automatic drive_and_check(input logic pv, input logic ku, input logic ks, input int code,
                                 input logic nx, input logic gd, input int key, input int gen,
                                 input logic en, input logic [1:0] af, input logic [1:0] ifl,
                                 input logic [2:0] acc);
    logic [2:0] e_pp, e_ex, e_km, e_perm, e_den, e_fw, e_dw;
    logic       e_fault;
    @(posedge clk);
    #1;
    priv_i       = pv;
    key_user_i   = ku;
    key_super_i  = ks;
    pte_pp0_i    = code[2];
    pte_pp_i     = code[1:0];
    pte_noexec_i = nx;
    pte_guard_i  = gd;
    pte_key_i    = KEY_W'(key);
    gen_i        = 2'(gen);
    keyprot_en_i = en;
    amr_i        = {NKEYS{~af}};
    amr_i[2*(NKEYS-1-key) +: 2] = af;
    iamr_i       = {NKEYS{~ifl}};
    iamr_i[2*(NKEYS-1-key) +: 2] = ifl;
    access_i     = acc;

    e_pp = model_pp(pv ? ks : ku, code);
    e_ex = (nx || gd) ? 3'b011 : 3'b111;
    e_km = 3'b111;
    if (en) begin
      e_km[1] = ~af[1];
      e_km[0] = ~af[0];
      e_km[2] = !(gen >= 2 && ifl[0]);
    end
    e_perm  = e_pp & e_ex & e_km;
    e_den   = acc & ~e_perm;
    e_fault = (e_den != 3'b000);
    e_fw = 3'b000;
    e_dw = 3'b000;
    if (e_fault && acc == 3'b100) begin
      e_fw[0] = ~e_ex[2];
      e_fw[1] = e_ex[2] & ~e_pp[2];
      e_fw[2] = ~e_km[2];
    end
    if (e_fault && acc != 3'b100) begin
      e_dw[0] = (acc & ~e_pp) != 3'b000;
      e_dw[1] = (acc == 3'b010);
      e_dw[2] = (acc & ~e_km) != 3'b000;
    end

    @(negedge clk);
    check3("R1 R2 R3 R4 R5 R6 R7 perm", perm_o, e_perm);
    check3("R7 R11 fault", {2'b00, fault_o}, {2'b00, e_fault});
    check3("R8 R10 fetch reasons", fetch_why_o, e_fw);
    check3("R9 R10 data reasons", data_why_o, e_dw);
  endtask

  initial begin
    int key;
    key = 0;
    // R11: an empty request on a page with no rights raises nothing
    drive_and_check(1'b0, 1'b1, 1'b1, 0, 1'b1, 1'b1, 3, 3, 1'b1, 2'b11, 2'b11, 3'b000);
    // R1: privilege picks the key (user key 1 code 0 no access, super key 0 full)
    drive_and_check(1'b1, 1'b1, 1'b0, 0, 1'b0, 1'b0, 0, 0, 1'b0, 2'b00, 2'b00, 3'b010);
    drive_and_check(1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0, 0, 0, 1'b0, 2'b00, 2'b00, 3'b010);
    // R6: masks fully set but disabled have no effect
    drive_and_check(1'b0, 1'b0, 1'b0, 1, 1'b0, 1'b0, 7, 3, 1'b0, 2'b11, 2'b11, 3'b100);
    // Exhaustive sweep, R1 through R11
    for (int pv = 0; pv < 2; pv++)
      for (int kk = 0; kk < 4; kk++)
        for (int code = 0; code < 8; code++)
          for (int ng = 0; ng < 4; ng++)
            for (int a = 0; a < 3; a++)
              for (int gen = 0; gen < 4; gen++)
                for (int en = 0; en < 2; en++)
                  for (int af = 0; af < 4; af++)
                    for (int ifl = 0; ifl < 4; ifl++) begin
                      drive_and_check(pv[0], kk[0], kk[1], code, ng[0], ng[1], key, gen,
                                      en[0], af[1:0], ifl[1:0], 3'(1 << a));
                      key = (key + 1) % NKEYS;
                    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule